// File: doc/BRIEF.md
# Per-Thread Retire-Stage Squash Controller

This block sits at the retire end of a multithreaded out-of-order core and decides, per hardware thread, when the reorder buffer must throw away speculative work. Three kinds of request can start a squash: a squash from the execute stage (with a sequence number, a flag that says whether the named instruction itself is discarded, a redirect PC and branch outcome bits), a trap that goes off a fixed number of cycles after it is raised, and a context-change request. Execute requests are filtered so that a younger squash can never overwrite an older one that is already in force.

Each accepted squash is announced on a registered broadcast toward the front end. It gives the squash point as a "done" sequence number, the PC to restart from and the mispredict and taken bits. The thread then stays in a squashing state until the reorder buffer reports that its walk is finished. While a thread is squashing, new instructions for it are refused. When every thread is squashing, retirement is also held off. The block keeps a live count of the squashing threads and a running count of the mispredicts it has accepted.

Top module: `commit_squash_ctrl`

## Requirements
- R1: After reset no broadcast squash is asserted, no thread is squashing, squash_count is 0, mispred_count is 0, every bit of ins_allow is 1 and retire_allow is 1.
- R2: An execute squash for a thread is accepted only if its sequence number is less than or equal to the thread's youngest-sequence register and the thread is not waiting on a trap. The youngest-sequence register resets to all ones and takes ins_seq whenever ins_vld and ins_allow are both high for that thread.
- R3: The effective squash point is the requested sequence number, minus one when ex_sq_self is 1. After an accepted execute squash the youngest-sequence register holds that effective value.
- R4: A trap raised at clock edge k (thread running, no context change pending) squashes at edge k+6. Its squash point is rob_head_seq minus one, or 0 if rob_empty is high. It zeroes the youngest-sequence register. Execute squashes that arrive during the wait are dropped.
- R5: A context-change request seen at edge k squashes at edge k+1, with the same squash point as a trap and the youngest-sequence register zeroed. If a trap is waiting, the trap is handled first and the context change follows one edge after it.
- R6: An accepted squash raises bc_squash for exactly one cycle after the edge. It puts the squash point on bc_done_seq, and bc_rob_squashing is high from that cycle on.
- R7: A trap or context-change squash drives bc_mispred and bc_taken to 0 and bc_next_pc to commit_pc. An execute squash forwards ex_sq_pc, ex_sq_mispred and ex_sq_taken.
- R8: rob_walk_done on a squashing thread returns it to running: bc_rob_squashing falls and squash_count drops by one after the edge.
- R9: While a thread is squashing, its ins_allow is 0 and ins_vld does not change its youngest-sequence register.
- R10: When every thread is squashing, retire_allow is 0.
- R11: mispred_count goes up by one for each accepted execute squash that has ex_sq_mispred set, and by nothing else.
- R12: squash_count always equals the number of threads with bc_rob_squashing high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_sq_vld | input | NTHR | Execute squash request, one bit per thread |
| ex_sq_seq | input | NTHR*SEQW | Execute squash sequence number per thread |
| ex_sq_self | input | NTHR | Also discard the named instruction |
| ex_sq_pc | input | NTHR*PCW | Redirect PC from execute |
| ex_sq_mispred | input | NTHR | Squash is a branch mispredict |
| ex_sq_taken | input | NTHR | Branch outcome of the squashing branch |
| trap_raise | input | NTHR | Start the trap delay for a thread |
| ctx_sq_req | input | NTHR | Context-change squash request |
| rob_empty | input | NTHR | Reorder buffer holds nothing for the thread |
| rob_head_seq | input | NTHR*SEQW | Sequence number at the reorder buffer head |
| rob_walk_done | input | NTHR | Squash walk finished for the thread |
| commit_pc | input | NTHR*PCW | Committed PC per thread |
| ins_vld | input | NTHR | Instruction inserted for the thread this cycle |
| ins_seq | input | NTHR*SEQW | Sequence number of the inserted instruction |
| bc_squash | output | NTHR | One-cycle squash broadcast |
| bc_rob_squashing | output | NTHR | Thread is in its squash walk |
| bc_done_seq | output | NTHR*SEQW | Squash point |
| bc_next_pc | output | NTHR*PCW | Restart PC |
| bc_mispred | output | NTHR | Broadcast mispredict flag |
| bc_taken | output | NTHR | Broadcast branch-taken flag |
| ins_allow | output | NTHR | Insertion permitted for the thread |
| retire_allow | output | 1 | Retirement permitted this cycle |
| squash_count | output | $clog2(NTHR+1) | Threads currently squashing |
| mispred_count | output | MCW | Accepted mispredict squashes, wrapping |

## Verification
The assertions assume that rob_walk_done is only meaningful while a thread is squashing, and that no thread is both squashing and told to stop by a fresh request outside the rules above. They also assume the execute stage holds no request during reset. The stimulus raises rob_walk_done only for threads that are squashing, clears every request right after the edge it targets, and keeps sequence numbers far enough from zero that the minus-one case does not wrap, except where wrap-free zero points are the subject under test.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [1:0] {
    TH_RUN   = 2'd0,
    TH_TRAPW = 2'd1,
    TH_SQ    = 2'd2
  } th_state_t;
endpackage

// File: rtl/csq_trap_delay.sv
module csq_trap_delay #(
  parameter int LAT = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic fire
);
  localparam int TW = (LAT > 1) ? $clog2(LAT) : 1;

  logic [TW-1:0] cnt;
  logic          busy;

  assign fire = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= TW'(LAT - 1);
    end else if (fire) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/csq_thread.sv
module csq_thread
  import csq_pkg::*;
#(
  parameter int SEQW = 16,
  parameter int PCW  = 32,
  parameter int LAT  = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ex_vld,
  input  logic [SEQW-1:0] ex_seq,
  input  logic            ex_self,
  input  logic [PCW-1:0]  ex_pc,
  input  logic            ex_mis,
  input  logic            ex_tkn,
  input  logic            trap_raise,
  input  logic            ctx_req,
  input  logic            rob_empty,
  input  logic [SEQW-1:0] rob_head,
  input  logic            walk_done,
  input  logic [PCW-1:0]  commit_pc,
  input  logic            ins_vld,
  input  logic [SEQW-1:0] ins_seq,
  input  logic            ins_ok,
  output logic            in_sq,
  output logic            enter_sq,
  output logic            leave_sq,
  output logic            mis_acc,
  output logic            bc_sq,
  output logic [SEQW-1:0] bc_done,
  output logic [PCW-1:0]  bc_pc,
  output logic            bc_mis,
  output logic            bc_tkn
);
  th_state_t       st, st_nx;
  logic [SEQW-1:0] yng;
  logic            ctx_pend;
  logic            tmr_fire;
  logic            trap_start, fire_trap, fire_ctx, ex_acc, any_sq, async_sq;
  logic [SEQW-1:0] eff_seq, head_pt, sq_pt;

  csq_trap_delay #(.LAT(LAT)) i_delay (
    .clk  (clk),
    .rst  (rst),
    .start(trap_start),
    .fire (tmr_fire)
  );

  always_comb begin
    fire_trap  = (st == TH_TRAPW) && tmr_fire;
    fire_ctx   = ctx_pend && (st != TH_TRAPW);
    async_sq   = fire_trap || fire_ctx;
    eff_seq    = ex_self ? (ex_seq - 1'b1) : ex_seq;
    ex_acc     = ex_vld && (st != TH_TRAPW) && !fire_ctx && (ex_seq <= yng);
    any_sq     = async_sq || ex_acc;
    trap_start = trap_raise && (st == TH_RUN) && !ctx_pend && !ex_acc;
    head_pt    = rob_empty ? '0 : (rob_head - 1'b1);
    sq_pt      = async_sq ? head_pt : eff_seq;
    mis_acc    = ex_acc && !async_sq && ex_mis;
    enter_sq   = any_sq && (st != TH_SQ);
    leave_sq   = (st == TH_SQ) && walk_done && !any_sq;
    st_nx      = st;
    if (any_sq)                        st_nx = TH_SQ;
    else if (trap_start)               st_nx = TH_TRAPW;
    else if (st == TH_SQ && walk_done) st_nx = TH_RUN;
  end

  assign in_sq = (st == TH_SQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= TH_RUN;
      yng      <= '1;
      ctx_pend <= 1'b0;
      bc_sq    <= 1'b0;
      bc_done  <= '0;
      bc_pc    <= '0;
      bc_mis   <= 1'b0;
      bc_tkn   <= 1'b0;
    end else begin
      st       <= st_nx;
      ctx_pend <= (ctx_pend && !fire_ctx) || ctx_req;
      bc_sq    <= any_sq;
      bc_mis   <= any_sq && !async_sq && ex_mis;
      bc_tkn   <= any_sq && !async_sq && ex_tkn;
      if (any_sq) begin
        bc_done <= sq_pt;
        bc_pc   <= async_sq ? commit_pc : ex_pc;
        yng     <= async_sq ? '0 : eff_seq;
      end else if (ins_vld && ins_ok) begin
        yng <= ins_seq;
      end
    end
  end
endmodule

// File: rtl/csq_tally.sv
module csq_tally #(
  parameter int NTHR = 2,
  parameter int MCW  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NTHR-1:0]            enter_sq,
  input  logic [NTHR-1:0]            leave_sq,
  input  logic [NTHR-1:0]            mis_acc,
  output logic [$clog2(NTHR+1)-1:0]  sq_cnt,
  output logic [MCW-1:0]             mis_cnt,
  output logic                       all_sq
);
  localparam int CW = $clog2(NTHR + 1);

  logic [CW-1:0]  n_in, n_out;
  logic [MCW-1:0] n_mis;

  always_comb begin
    n_in  = '0;
    n_out = '0;
    n_mis = '0;
    for (int i = 0; i < NTHR; i++) begin
      n_in  = n_in  + CW'(enter_sq[i]);
      n_out = n_out + CW'(leave_sq[i]);
      n_mis = n_mis + MCW'(mis_acc[i]);
    end
  end

  assign all_sq = (sq_cnt == CW'(NTHR));

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_cnt  <= '0;
      mis_cnt <= '0;
    end else begin
      sq_cnt  <= sq_cnt + n_in - n_out;
      mis_cnt <= mis_cnt + n_mis;
    end
  end
endmodule

// File: rtl/commit_squash_ctrl.sv
module commit_squash_ctrl #(
  parameter int NTHR     = 2,
  parameter int SEQW     = 16,
  parameter int PCW      = 32,
  parameter int MCW      = 8,
  parameter int TRAP_LAT = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NTHR-1:0]           ex_sq_vld,
  input  logic [NTHR*SEQW-1:0]      ex_sq_seq,
  input  logic [NTHR-1:0]           ex_sq_self,
  input  logic [NTHR*PCW-1:0]       ex_sq_pc,
  input  logic [NTHR-1:0]           ex_sq_mispred,
  input  logic [NTHR-1:0]           ex_sq_taken,
  input  logic [NTHR-1:0]           trap_raise,
  input  logic [NTHR-1:0]           ctx_sq_req,
  input  logic [NTHR-1:0]           rob_empty,
  input  logic [NTHR*SEQW-1:0]      rob_head_seq,
  input  logic [NTHR-1:0]           rob_walk_done,
  input  logic [NTHR*PCW-1:0]       commit_pc,
  input  logic [NTHR-1:0]           ins_vld,
  input  logic [NTHR*SEQW-1:0]      ins_seq,
  output logic [NTHR-1:0]           bc_squash,
  output logic [NTHR-1:0]           bc_rob_squashing,
  output logic [NTHR*SEQW-1:0]      bc_done_seq,
  output logic [NTHR*PCW-1:0]       bc_next_pc,
  output logic [NTHR-1:0]           bc_mispred,
  output logic [NTHR-1:0]           bc_taken,
  output logic [NTHR-1:0]           ins_allow,
  output logic                      retire_allow,
  output logic [$clog2(NTHR+1)-1:0] squash_count,
  output logic [MCW-1:0]            mispred_count
);
  logic [NTHR-1:0] enter_sq, leave_sq, mis_acc, in_sq;
  logic            all_sq;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    csq_thread #(.SEQW(SEQW), .PCW(PCW), .LAT(TRAP_LAT)) i_thr (
      .clk       (clk),
      .rst       (rst),
      .ex_vld    (ex_sq_vld[t]),
      .ex_seq    (ex_sq_seq[t*SEQW +: SEQW]),
      .ex_self   (ex_sq_self[t]),
      .ex_pc     (ex_sq_pc[t*PCW +: PCW]),
      .ex_mis    (ex_sq_mispred[t]),
      .ex_tkn    (ex_sq_taken[t]),
      .trap_raise(trap_raise[t]),
      .ctx_req   (ctx_sq_req[t]),
      .rob_empty (rob_empty[t]),
      .rob_head  (rob_head_seq[t*SEQW +: SEQW]),
      .walk_done (rob_walk_done[t]),
      .commit_pc (commit_pc[t*PCW +: PCW]),
      .ins_vld   (ins_vld[t]),
      .ins_seq   (ins_seq[t*SEQW +: SEQW]),
      .ins_ok    (ins_allow[t]),
      .in_sq     (in_sq[t]),
      .enter_sq  (enter_sq[t]),
      .leave_sq  (leave_sq[t]),
      .mis_acc   (mis_acc[t]),
      .bc_sq     (bc_squash[t]),
      .bc_done   (bc_done_seq[t*SEQW +: SEQW]),
      .bc_pc     (bc_next_pc[t*PCW +: PCW]),
      .bc_mis    (bc_mispred[t]),
      .bc_tkn    (bc_taken[t])
    );
    assign ins_allow[t] = !in_sq[t] && !all_sq;
  end

  csq_tally #(.NTHR(NTHR), .MCW(MCW)) i_tally (
    .clk     (clk),
    .rst     (rst),
    .enter_sq(enter_sq),
    .leave_sq(leave_sq),
    .mis_acc (mis_acc),
    .sq_cnt  (squash_count),
    .mis_cnt (mispred_count),
    .all_sq  (all_sq)
  );

  assign bc_rob_squashing = in_sq;
  assign retire_allow     = !all_sq;
endmodule

// File: rtl/csq_check.sv
module csq_check #(
  parameter int NTHR = 2,
  parameter int SEQW = 16,
  parameter int PCW  = 32,
  parameter int MCW  = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NTHR-1:0]           ex_sq_vld,
  input logic [NTHR*SEQW-1:0]      ex_sq_seq,
  input logic [NTHR-1:0]           ex_sq_self,
  input logic [NTHR*PCW-1:0]       ex_sq_pc,
  input logic [NTHR-1:0]           ex_sq_mispred,
  input logic [NTHR-1:0]           ex_sq_taken,
  input logic [NTHR-1:0]           trap_raise,
  input logic [NTHR-1:0]           ctx_sq_req,
  input logic [NTHR-1:0]           rob_empty,
  input logic [NTHR*SEQW-1:0]      rob_head_seq,
  input logic [NTHR-1:0]           rob_walk_done,
  input logic [NTHR*PCW-1:0]       commit_pc,
  input logic [NTHR-1:0]           ins_vld,
  input logic [NTHR*SEQW-1:0]      ins_seq,
  input logic [NTHR-1:0]           bc_squash,
  input logic [NTHR-1:0]           bc_rob_squashing,
  input logic [NTHR*SEQW-1:0]      bc_done_seq,
  input logic [NTHR*PCW-1:0]       bc_next_pc,
  input logic [NTHR-1:0]           bc_mispred,
  input logic [NTHR-1:0]           bc_taken,
  input logic [NTHR-1:0]           ins_allow,
  input logic                      retire_allow,
  input logic [$clog2(NTHR+1)-1:0] squash_count,
  input logic [MCW-1:0]            mispred_count
);
  p_count_match_r12: assert property (@(posedge clk) disable iff (rst)
    squash_count == $countones(bc_rob_squashing));

  p_no_retire_r10: assert property (@(posedge clk) disable iff (rst)
    (&bc_rob_squashing) |-> !retire_allow);

  p_mis_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (ex_sq_vld == '0) |=> $stable(mispred_count));

  for (genvar t = 0; t < NTHR; t++) begin : g_chk
    p_bc_walk_r6: assert property (@(posedge clk) disable iff (rst)
      bc_squash[t] |-> bc_rob_squashing[t]);

    p_no_insert_r9: assert property (@(posedge clk) disable iff (rst)
      bc_rob_squashing[t] |-> !ins_allow[t]);

    p_mis_needs_sq_r7: assert property (@(posedge clk) disable iff (rst)
      (bc_mispred[t] || bc_taken[t]) |-> bc_squash[t]);

    p_walk_exit_r8: assert property (@(posedge clk) disable iff (rst)
      (bc_rob_squashing[t] && rob_walk_done[t]) |=>
        (!bc_rob_squashing[t] || bc_squash[t]));
  end
endmodule

bind commit_squash_ctrl csq_check #(
  .NTHR(NTHR), .SEQW(SEQW), .PCW(PCW), .MCW(MCW)
) i_csq_check (.*);

// File: tb/test_commit_squash_ctrl.sv
module test_commit_squash_ctrl;
  localparam int CLK_P = 10;
  localparam int N = 2;
  localparam int S = 16;
  localparam int P = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]   ex_sq_vld = '0, ex_sq_self = '0, ex_sq_mispred = '0, ex_sq_taken = '0;
  logic [N*S-1:0] ex_sq_seq = '0, rob_head_seq = '0, ins_seq = '0;
  logic [N*P-1:0] ex_sq_pc = '0, commit_pc = '0;
  logic [N-1:0]   trap_raise = '0, ctx_sq_req = '0, rob_empty = '0, rob_walk_done = '0, ins_vld = '0;
  logic [N-1:0]   bc_squash, bc_rob_squashing, bc_mispred, bc_taken, ins_allow;
  logic [N*S-1:0] bc_done_seq;
  logic [N*P-1:0] bc_next_pc;
  logic           retire_allow;
  logic [1:0]     squash_count;
  logic [7:0]     mispred_count;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int exp_mis = 0;

  always #(CLK_P/2) clk = ~clk;

  commit_squash_ctrl i_commit_squash_ctrl (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    ex_sq_vld = '0; trap_raise = '0; ctx_sq_req = '0;
    rob_walk_done = '0; ins_vld = '0;
  endtask

  task automatic insert(int t, logic [15:0] s);
    ins_vld[t] = 1'b1; ins_seq[t*S +: S] = s;
    tick(); clear_in();
  endtask

  task automatic set_ex(int t, logic [15:0] s, bit self, logic [31:0] pc, bit mis, bit tkn);
    ex_sq_vld[t] = 1'b1; ex_sq_seq[t*S +: S] = s; ex_sq_self[t] = self;
    ex_sq_pc[t*P +: P] = pc; ex_sq_mispred[t] = mis; ex_sq_taken[t] = tkn;
  endtask

  task automatic walk(int t);
    rob_walk_done[t] = 1'b1;
    tick(); clear_in();
    chk("R8 walk exit", {31'd0, bc_rob_squashing[t]}, 32'd0);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst = 1'b0; tick();
    // R1 reset state
    chk("R1 bc_squash", {30'd0, bc_squash}, 32'd0);
    chk("R1 count", {30'd0, squash_count}, 32'd0);
    chk("R1 mispred", {24'd0, mispred_count}, 32'd0);
    chk("R1 ins_allow", {30'd0, ins_allow}, 32'd3);
    chk("R1 retire", {31'd0, retire_allow}, 32'd1);

    // R2 R3 R6 R7 R11 R12 sweep
    for (int t = 0; t < N; t++) begin
      for (int yi = 0; yi < 2; yi++) begin
        for (int d = -2; d <= 2; d++) begin
          for (int sf = 0; sf < 2; sf++) begin
            logic [15:0] y, s, e;
            logic [31:0] pc;
            bit acc, mis, tkn;
            y = (yi == 0) ? 16'd10 : 16'd200;
            s = 16'(int'(y) + d);
            e = sf ? s - 16'd1 : s;
            pc = 32'h1000 + 32'(t*100 + yi*10 + (d+2)*2 + sf);
            mis = d[0]; tkn = sf[0];
            acc = (s <= y);
            insert(t, y);
            set_ex(t, s, sf[0], pc, mis, tkn);
            tick(); clear_in();
            if (acc && mis) exp_mis++;
            chk("R2 accept", {31'd0, bc_squash[t]}, {31'd0, acc});
            chk("R11 mispred count", {24'd0, mispred_count}, 32'(exp_mis) & 32'hff);
            if (acc) begin
              chk("R3 done seq", {16'd0, bc_done_seq[t*S +: S]}, {16'd0, e});
              chk("R7 ex pc", bc_next_pc[t*P +: P], pc);
              chk("R7 ex mis", {31'd0, bc_mispred[t]}, {31'd0, mis});
              chk("R7 ex taken", {31'd0, bc_taken[t]}, {31'd0, tkn});
              chk("R6 rob squashing", {31'd0, bc_rob_squashing[t]}, 32'd1);
              chk("R12 count", {30'd0, squash_count}, 32'd1);
              chk("R9 no insert", {31'd0, ins_allow[t]}, 32'd0);
              tick();
              chk("R6 pulse", {31'd0, bc_squash[t]}, 32'd0);
              walk(t);
              chk("R12 count back", {30'd0, squash_count}, 32'd0);
            end
          end
        end
      end
    end

    // R9 inserts ignored while squashing
    insert(0, 16'd50);
    set_ex(0, 16'd50, 1'b0, 32'h2000, 1'b0, 1'b0);
    tick(); clear_in();
    insert(0, 16'd80);
    walk(0);
    set_ex(0, 16'd60, 1'b0, 32'h2004, 1'b0, 1'b0);
    tick(); clear_in();
    chk("R9 youngest kept", {31'd0, bc_squash[0]}, 32'd0);
    set_ex(0, 16'd50, 1'b0, 32'h2008, 1'b0, 1'b0);
    tick(); clear_in();
    chk("R3 youngest is eff", {31'd0, bc_squash[0]}, 32'd1);
    walk(0);

    // R10 all threads squashing
    insert(0, 16'd30); insert(1, 16'd30);
    set_ex(0, 16'd20, 1'b0, 32'h3000, 1'b0, 1'b0);
    set_ex(1, 16'd21, 1'b0, 32'h3100, 1'b0, 1'b0);
    tick(); clear_in();
    chk("R10 retire off", {31'd0, retire_allow}, 32'd0);
    chk("R12 count two", {30'd0, squash_count}, 32'd2);
    chk("R10 ins off", {30'd0, ins_allow}, 32'd0);
    walk(0);
    chk("R10 retire on", {31'd0, retire_allow}, 32'd1);
    chk("R8 count one", {30'd0, squash_count}, 32'd1);
    chk("R9 ins t0 back", {30'd0, ins_allow}, 32'd1);
    walk(1);

    // R5 context change
    rob_empty[1] = 1'b0; rob_head_seq[1*S +: S] = 16'd300; commit_pc[1*P +: P] = 32'hABCD;
    ctx_sq_req[1] = 1'b1;
    tick(); clear_in();
    chk("R5 not yet", {31'd0, bc_squash[1]}, 32'd0);
    tick();
    chk("R5 fire", {31'd0, bc_squash[1]}, 32'd1);
    chk("R5 point", {16'd0, bc_done_seq[1*S +: S]}, 32'd299);
    chk("R7 ctx pc", bc_next_pc[1*P +: P], 32'hABCD);
    chk("R7 ctx mis", {31'd0, bc_mispred[1]}, 32'd0);
    walk(1);
    set_ex(1, 16'd1, 1'b0, 32'h4000, 1'b0, 1'b0);
    tick(); clear_in();
    chk("R5 youngest zero", {31'd0, bc_squash[1]}, 32'd0);
    set_ex(1, 16'd0, 1'b0, 32'h4004, 1'b0, 1'b0);
    tick(); clear_in();
    chk("R5 zero accepted", {31'd0, bc_squash[1]}, 32'd1);
    walk(1);

    // R4 trap on empty buffer, execute squashes dropped during wait
    insert(0, 16'd40);
    rob_empty[0] = 1'b1; commit_pc[0*P +: P] = 32'h5555;
    trap_raise[0] = 1'b1;
    tick(); clear_in();
    set_ex(0, 16'd5, 1'b0, 32'h6000, 1'b1, 1'b1);
    for (int i = 1; i <= 5; i++) begin
      tick();
      chk("R4 waiting", {31'd0, bc_squash[0]}, 32'd0);
    end
    tick(); clear_in();
    chk("R4 fire", {31'd0, bc_squash[0]}, 32'd1);
    chk("R4 point empty", {16'd0, bc_done_seq[0*S +: S]}, 32'd0);
    chk("R7 trap pc", bc_next_pc[0*P +: P], 32'h5555);
    chk("R7 trap mis", {31'd0, bc_mispred[0]}, 32'd0);
    chk("R4 ex dropped", {24'd0, mispred_count}, 32'(exp_mis) & 32'hff);
    walk(0);
    set_ex(0, 16'd1, 1'b0, 32'h6004, 1'b0, 1'b0);
    tick(); clear_in();
    chk("R4 youngest zero", {31'd0, bc_squash[0]}, 32'd0);

    // R5 trap and context change together
    rob_empty[1] = 1'b0; rob_head_seq[1*S +: S] = 16'd77;
    trap_raise[1] = 1'b1;
    tick(); clear_in();
    ctx_sq_req[1] = 1'b1;
    tick(); clear_in();
    for (int i = 2; i <= 5; i++) begin
      tick();
      chk("R5 ctx held by trap", {31'd0, bc_squash[1]}, 32'd0);
    end
    tick();
    chk("R4 trap first", {31'd0, bc_squash[1]}, 32'd1);
    chk("R4 point head", {16'd0, bc_done_seq[1*S +: S]}, 32'd76);
    tick();
    chk("R5 ctx follows", {31'd0, bc_squash[1]}, 32'd1);
    tick();
    chk("R5 ctx once", {31'd0, bc_squash[1]}, 32'd0);
    walk(1);
    chk("R12 final count", {30'd0, squash_count}, 32'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule